// File: doc/BRIEF.md
# Transmit Trigger Generator

This block drives a debug trigger line that frames each outgoing bus transmission, so that a scope or a logic analyser can be armed on it. It watches three sources: bus activity strobes, which restart a quiet-time timer; a transmit scheduler, which announces a pending frame together with its planned start offset and whether the frame is a short acknowledge-type reply; and the transmitter's completion and collision strobes.

A frame that follows recent bus traffic is a scheduled frame. For such a frame the trigger rises exactly one bit time before the frame begins. If the bus has been quiet for longer than the threshold, or the frame is a reply, the trigger rises and the frame begins in the same cycle. The block pulses a start strobe on the cycle the frame must begin, so the transmitter and the trigger share one time base. The trigger falls after the frame completes or a collision is reported. A single enable input gates the whole function.

Top module: `tx_trigger_gen`

## Requirements
- R1: After reset `trig_out` and `tx_start` are low, and the bus counts as quiet for longer than the threshold.
- R2: While `trig_en` is low, requests are ignored: `trig_out` and `tx_start` stay low.
- R3: When `trig_en` is low in a cycle while a frame is pending or in progress, `trig_out` is low from the next cycle and no `tx_start` follows for that frame.
- R4: A scheduled request in cycle 0 with `sched_delay` = D > BIT_CYC raises `trig_out` in cycle D-BIT_CYC and pulses `tx_start` in cycle D.
- R5: A scheduled request with D <= BIT_CYC keeps the full lead: `trig_out` rises in cycle 1 and `tx_start` pulses in cycle BIT_CYC+1.
- R6: A request made when no `bus_act` strobe came in the last IDLE_CYC cycles (or none since reset) raises `trig_out` and pulses `tx_start` both in cycle 1.
- R7: A request with `sched_resp` high is handled as in R6, however recent the bus activity.
- R8: A `tx_done` strobe while the frame is in progress makes `trig_out` low from the next cycle.
- R9: A `tx_collision` strobe while `trig_out` is high makes `trig_out` low from the next cycle; if it comes before the start, no `tx_start` follows.
- R10: A request exactly IDLE_CYC cycles after a `bus_act` strobe is scheduled; one made IDLE_CYC+1 cycles after is handled as in R6.
- R11: A request that arrives while an earlier frame is pending or in progress is ignored.
- R12: `tx_start` is high for exactly one cycle per frame and only while `trig_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_en | input | 1 | Enables the trigger function |
| bus_act | input | 1 | One-cycle strobe for any activity seen on the bus |
| sched_valid | input | 1 | One-cycle strobe: a frame is pending |
| sched_resp | input | 1 | Pending frame is an acknowledge-type reply |
| sched_delay | input | DLY_W | Planned start, in cycles after the request cycle |
| tx_done | input | 1 | Strobe: the transmission is complete |
| tx_collision | input | 1 | Strobe: a collision has been detected |
| trig_out | output | 1 | Debug trigger line |
| tx_start | output | 1 | One-cycle strobe on the cycle the frame begins |

## Verification
All results are registered. A strobe sampled in cycle 0 affects the outputs from cycle 1: the fall after a done, collision or enable drop, and both edges of an immediate frame. For a scheduled frame the rise is due at cycle D-BIT_CYC and the start at D, or at 1 and BIT_CYC+1 when the offset is short. The driver stamps each stimulus with the bench cycle counter and queues the rise, start and fall events at those absolute cycles. The monitor samples on the falling clock edge, detects each edge or pulse, and compares its kind and cycle with the head of the queue, so an early, late, missing or extra event is reported.

// File: rtl/tx_trigger_gen_pkg.sv
package tx_trigger_gen_pkg;

   typedef enum logic [1:0] {
      TG_IDLE   = 2'd0,
      TG_HOLD   = 2'd1,
      TG_LEAD   = 2'd2,
      TG_ACTIVE = 2'd3
   } tg_state_e;

   typedef struct packed {
      logic valid;
      logic resp;
   } tg_req_t;

   function automatic int tg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tx_trigger_quiet_timer.sv
module tx_trigger_quiet_timer #(
   parameter int IDLE_CYC = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_act,
   output logic recent
);
   localparam int CW = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC + 1);

   initial begin
      if (IDLE_CYC < 0) $error("IDLE_CYC must not be negative");
   end

   generate
      if (IDLE_CYC == 0) begin : g_no_window
         assign recent = bus_act;
      end else begin : g_window
         localparam logic [CW-1:0] SAT = CW'(IDLE_CYC);
         logic [CW-1:0] since_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               since_q <= SAT;
            end else if (bus_act) begin
               since_q <= '0;
            end else if (since_q != SAT) begin
               since_q <= since_q + 1'b1;
            end
         end

         assign recent = bus_act || (since_q < SAT);

         a_r10_act_restarts: assert property (@(posedge clk) disable iff (!rst_n)
            bus_act |=> recent);
      end
   endgenerate

endmodule

// File: rtl/tx_trigger_seq.sv
module tx_trigger_seq
   import tx_trigger_gen_pkg::*;
#(
   parameter int BIT_CYC = 1664,
   parameter int DLY_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  tg_req_t          req,
   input  logic [DLY_W-1:0] dly,
   input  logic             recent,
   input  logic             done,
   input  logic             coll,
   output logic             trig,
   output logic             start
);
   localparam int BW   = (BIT_CYC < 2) ? 1 : $clog2(BIT_CYC + 2);
   localparam int CW   = tg_max(DLY_W, BW) + 1;
   localparam logic [CW-1:0] BIT_V   = CW'(BIT_CYC);
   localparam logic [CW-1:0] BIT_P1  = CW'(BIT_CYC + 1);
   localparam logic [CW-1:0] BIT_M1  = CW'(BIT_CYC - 1);
   localparam logic [CW-1:0] BIT_P2  = CW'(BIT_CYC + 2);

   initial begin
      if (BIT_CYC < 1) $error("BIT_CYC must be at least 1");
      if (DLY_W < 1)   $error("DLY_W must be at least 1");
   end

   tg_state_e      st_q;
   logic [CW-1:0]  cnt_q;
   logic           trig_q;
   logic           start_q;
   logic [CW-1:0]  dly_x;
   logic           go_now;
   logic           long_off;

   assign dly_x    = CW'(dly);
   assign go_now   = req.resp || !recent;
   assign long_off = dly_x > BIT_V;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= TG_IDLE;
         cnt_q   <= '0;
         trig_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (!en) begin
            st_q   <= TG_IDLE;
            trig_q <= 1'b0;
         end else begin
            unique case (st_q)
               TG_IDLE: begin
                  if (req.valid) begin
                     if (go_now) begin
                        trig_q  <= 1'b1;
                        start_q <= 1'b1;
                        st_q    <= TG_ACTIVE;
                     end else if (long_off && (dly_x != BIT_P1)) begin
                        cnt_q <= dly_x - BIT_P2;
                        st_q  <= TG_HOLD;
                     end else begin
                        trig_q <= 1'b1;
                        cnt_q  <= BIT_M1;
                        st_q   <= TG_LEAD;
                     end
                  end
               end
               TG_HOLD: begin
                  if (cnt_q == '0) begin
                     trig_q <= 1'b1;
                     cnt_q  <= BIT_M1;
                     st_q   <= TG_LEAD;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               TG_LEAD: begin
                  if (coll) begin
                     trig_q <= 1'b0;
                     st_q   <= TG_IDLE;
                  end else if (cnt_q == '0) begin
                     start_q <= 1'b1;
                     st_q    <= TG_ACTIVE;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               TG_ACTIVE: begin
                  if (done || coll) begin
                     trig_q <= 1'b0;
                     st_q   <= TG_IDLE;
                  end
               end
               default: st_q <= TG_IDLE;
            endcase
         end
      end
   end

   assign trig  = trig_q;
   assign start = start_q;

   a_r3_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!trig_q && !start_q));
   a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   a_r12_start_in_trig: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> trig_q);
   a_r9_coll_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q && coll) |=> !trig_q);
   a_r8_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TG_ACTIVE && done) |=> !trig_q);
   a_r7_reply_now: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st_q == TG_IDLE && req.valid && req.resp) |=> (trig_q && start_q));
   a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st_q == TG_HOLD && cnt_q != '0) |=> !trig_q);

endmodule

// File: rtl/tx_trigger_gen.sv
module tx_trigger_gen
   import tx_trigger_gen_pkg::*;
#(
   parameter int BIT_CYC  = 1664,
   parameter int IDLE_CYC = 8320,
   parameter int DLY_W    = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_en,
   input  logic             bus_act,
   input  logic             sched_valid,
   input  logic             sched_resp,
   input  logic [DLY_W-1:0] sched_delay,
   input  logic             tx_done,
   input  logic             tx_collision,
   output logic             trig_out,
   output logic             tx_start
);
   logic    recent;
   tg_req_t req;

   assign req.valid = sched_valid;
   assign req.resp  = sched_resp;

   tx_trigger_quiet_timer #(.IDLE_CYC(IDLE_CYC)) u_quiet (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_act (bus_act),
      .recent  (recent)
   );

   tx_trigger_seq #(.BIT_CYC(BIT_CYC), .DLY_W(DLY_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (trig_en),
      .req    (req),
      .dly    (sched_delay),
      .recent (recent),
      .done   (tx_done),
      .coll   (tx_collision),
      .trig   (trig_out),
      .start  (tx_start)
   );

endmodule

// File: tb/tx_trigger_gen_tb_top.sv
module tx_trigger_gen_tb_top;
   localparam int BIT   = 16;
   localparam int IDLE  = 100;
   localparam int DW    = 16;
   localparam int K_RISE = 0, K_START = 1, K_FALL = 2;

   typedef struct {
      int    cyc;
      int    kind;
      string tag;
   } ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_en = 1'b1, bus_act = 1'b0, sched_valid = 1'b0, sched_resp = 1'b0;
   logic [DW-1:0] sched_delay = '0;
   logic tx_done = 1'b0, tx_collision = 1'b0;
   logic trig_out, tx_start;

   int cyc = 0;
   int last_act = -1000000;
   int n_run = 0, n_fail = 0;
   bit finished = 0;
   ev_t exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tx_trigger_gen #(.BIT_CYC(BIT), .IDLE_CYC(IDLE), .DLY_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .bus_act(bus_act),
      .sched_valid(sched_valid), .sched_resp(sched_resp), .sched_delay(sched_delay),
      .tx_done(tx_done), .tx_collision(tx_collision),
      .trig_out(trig_out), .tx_start(tx_start)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic push(input int c, input int k, input string tag);
      ev_t e;
      e.cyc = c; e.kind = k; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares observed edges/pulses with the scoreboard head
   logic prev_trig = 1'b0;
   task automatic observe(input int k);
      ev_t e;
      if (exp_q.size() == 0) begin
         check(0, "unexpected event", k, -1);
      end else begin
         e = exp_q.pop_front();
         check(e.kind == k, {e.tag, " kind"}, k, e.kind);
         check(e.cyc == cyc, {e.tag, " cycle"}, cyc, e.cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (trig_out && !prev_trig) observe(K_RISE);
         if (tx_start) observe(K_START);
         if (!trig_out && prev_trig) observe(K_FALL);
      end
      prev_trig = trig_out;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic activity();
      @(negedge clk);
      bus_act = 1'b1; last_act = cyc;
      @(negedge clk);
      bus_act = 1'b0;
   endtask

   // request in the current negedge cycle c; pushes expected events
   task automatic request(input int d, input bit resp, input bit want_start, input string tag);
      int c;
      @(negedge clk);
      c = cyc;
      sched_valid = 1'b1; sched_resp = resp; sched_delay = DW'(d);
      if (resp || (c - last_act) > IDLE) begin
         push(c + 1, K_RISE, tag);
         if (want_start) push(c + 1, K_START, tag);
      end else if (d > BIT) begin
         push(c + d - BIT, K_RISE, tag);
         if (want_start) push(c + d, K_START, tag);
      end else begin
         push(c + 1, K_RISE, tag);
         if (want_start) push(c + 1 + BIT, K_START, tag);
      end
      @(negedge clk);
      sched_valid = 1'b0; sched_resp = 1'b0;
   endtask

   task automatic raw_request(input int d, input bit resp);
      @(negedge clk);
      sched_valid = 1'b1; sched_resp = resp; sched_delay = DW'(d);
      @(negedge clk);
      sched_valid = 1'b0; sched_resp = 1'b0;
   endtask

   task automatic finish_done(input string tag);
      @(negedge clk);
      tx_done = 1'b1; push(cyc + 1, K_FALL, tag);
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic collide(input string tag);
      @(negedge clk);
      tx_collision = 1'b1; push(cyc + 1, K_FALL, tag);
      @(negedge clk);
      tx_collision = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      tick(4);
      // R1: reset state
      check(trig_out == 1'b0, "R1 trig after reset", trig_out, 0);
      check(tx_start == 1'b0, "R1 start after reset", tx_start, 0);
      rst_n = 1'b1;
      tick(2);
      check(trig_out == 1'b0, "R1 trig idle", trig_out, 0);

      // R6 / R1: no activity since reset, immediate frame
      request(50, 0, 1, "R6 quiet since reset");
      tick(4);
      finish_done("R8 done after immediate");
      tick(3);

      // R4: scheduled, long offset
      activity();
      request(40, 0, 1, "R4 scheduled lead");
      tick(42);
      finish_done("R8 done after scheduled");
      tick(3);

      // R5: short offset keeps full lead
      activity();
      request(10, 0, 1, "R5 short offset");
      tick(BIT + 3);
      finish_done("R8 done after short");
      tick(3);

      // edge of R4: offset one past the bit time
      activity();
      request(BIT + 1, 0, 1, "R4 offset bit+1");
      tick(BIT + 3);
      finish_done("R8 done after bit+1");
      tick(3);

      // R7: reply goes out at once despite recent activity
      activity();
      request(40, 1, 1, "R7 reply immediate");
      tick(3);
      finish_done("R8 done after reply");
      tick(3);

      // R9: collision during lead, no start
      activity();
      request(40, 0, 0, "R9 collision in lead");
      tick(28);
      collide("R9 fall in lead");
      tick(30);
      check(tx_start == 1'b0 && trig_out == 1'b0, "R9 no start after abort", tx_start, 0);

      // R9: collision while active
      request(40, 1, 1, "R9 active frame");
      tick(3);
      collide("R9 fall while active");
      tick(3);

      // R11: request while busy is ignored
      request(40, 1, 1, "R11 first frame");
      tick(2);
      raw_request(5, 1);
      tick(3);
      finish_done("R11 only one fall");
      tick(3);
      activity();
      request(60, 0, 1, "R11 hold frame");
      tick(5);
      raw_request(5, 1);
      tick(60);
      finish_done("R11 hold done");
      tick(3);

      // R3: enable drop during lead
      activity();
      request(40, 0, 0, "R3 abandoned");
      tick(28);
      @(negedge clk);
      trig_en = 1'b0; push(cyc + 1, K_FALL, "R3 enable drop");
      tick(30);
      check(trig_out == 1'b0 && tx_start == 1'b0, "R3 stays low", trig_out, 0);
      // R2: requests ignored while disabled
      raw_request(5, 1);
      tick(30);
      check(trig_out == 1'b0, "R2 disabled trig", trig_out, 0);
      check(tx_start == 1'b0, "R2 disabled start", tx_start, 0);
      @(negedge clk);
      trig_en = 1'b1;
      tick(2);

      // R10: window boundaries
      activity();
      while (cyc + 1 - last_act < IDLE) @(negedge clk);
      request(40, 0, 1, "R10 at threshold scheduled");
      tick(42);
      finish_done("R10 done a");
      tick(3);
      activity();
      while (cyc + 1 - last_act < IDLE + 1) @(negedge clk);
      request(40, 0, 1, "R10 past threshold immediate");
      tick(3);
      finish_done("R10 done b");
      tick(5);

      check(exp_q.size() == 0, "R12 all expected events seen", exp_q.size(), 0);
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", cyc, 0);
      summary();
   end

endmodule